// File: doc/BRIEF.md
# Two-Priority Interrupt Control Register

This block is an 8-bit interrupt control register for a small microcontroller core. It holds a master enable, a second enable for peripheral or low-priority sources, three local enables and three event flags. The three events are a timer overflow pulse, an edge pulse from an external interrupt pin, and a change on the watched upper pins of an input port. Software reads the whole register combinationally and writes it as one byte. Flags can also be polled, because a flag is set whether or not anything enables it.

Two request outputs go to the core sequencer. A priority-mode input selects how the top two bits are read. With the mode off, bit 7 is a plain global enable and bit 6 gates peripheral requests. With the mode on, bit 7 enables high-priority requests and bit 6 enables low-priority peripheral requests. Clearing bit 7 still silences everything. The three local events count as high priority.

The port-change flag follows a persistent mismatch between the watched pins and a snapshot taken at the last port-read strobe. A software clear holds only after a port read has ended the mismatch.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset every register bit reads 0, with the port-change flag reset value set by parameter (default 0), and both request outputs are low.
- R2: A write stores wr_data_i in all eight bits: bit 7 master enable, bit 6 peripheral/low enable, bit 5 timer enable, bit 4 external enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external flag, bit 0 port-change flag. The enable bits change only on a write.
- R3: A timer overflow pulse sets bit 2 on the next clock edge, whatever the enable bits hold.
- R4: An external edge pulse sets bit 1 on the next clock edge, whatever the enable bits hold.
- R5: Bit 0 is set at every clock edge where the watched pins differ from the snapshot. The snapshot resets to 0 and loads the pins at each port-read strobe.
- R6: While the mismatch lasts, writing 0 to bit 0 does not hold. After a port-read strobe has ended the mismatch, a write of 0 clears bit 0 and it stays clear.
- R7: When a hardware set and a software write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R8: Hardware never clears a flag. Without a write, a set flag stays set.
- R9: With priority mode off, hp_irq_o = bit7 AND (any flag whose enable is set, OR bit6 AND any peripheral request on either input). lp_irq_o stays 0.
- R10: With priority mode on, hp_irq_o = bit7 AND (any enabled flag OR any high-priority peripheral request), and lp_irq_o = bit7 AND bit6 AND any low-priority peripheral request.
- R11: With bit 7 clear, both request outputs are low in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register contents |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_edge_i | input | 1 | External pin edge pulse |
| port_hi_i | input | WATCH_W (4) | Watched upper port pins |
| port_rd_i | input | 1 | Port-read strobe, loads the snapshot |
| prio_mode_i | input | 1 | Priority mode select |
| hp_per_req_i | input | N_PER (4) | Enabled peripheral requests tagged high priority |
| lp_per_req_i | input | N_PER (4) | Enabled peripheral requests tagged low priority |
| hp_irq_o | output | 1 | High-priority interrupt request |
| lp_irq_o | output | 1 | Low-priority interrupt request |

## Verification
The checker enforces the following on every cycle:
- an event pulse leaves its flag set one edge later;
- a clearing write loses to a simultaneous timer event;
- flags never fall and enables never move without a write;
- a clear bit 7 silences both outputs;
- lp_irq_o is never raised outside priority mode or without bit 6 and a low-priority request.

The bench scenarios cover the behaviours that depend on order. These are: the port-change clear that fails until a port read ends the mismatch, the mismatch created when the pins return to a value the snapshot no longer holds, and the exact request levels for each enable pattern in both modes.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned N_SRC   = 3;
   localparam int unsigned FLG_LSB = 0;
   localparam int unsigned ENA_LSB = 3;
   localparam int unsigned BIT_PE  = 6;
   localparam int unsigned BIT_GE  = 7;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_TMR  = 2'd2
   } src_e;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hw_set_i,
   input  logic wr_en_i,
   input  logic wr_bit_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= RST_VAL;
      else if (hw_set_i) q <= 1'b1;
      else if (wr_en_i)  q <= wr_bit_i;
   end

   assign q_o = q;
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
   parameter int unsigned WATCH_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [WATCH_W-1:0] pins_i,
   input  logic               rd_stb_i,
   output logic               mismatch_o
);
   logic [WATCH_W-1:0] snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       snap_q <= '0;
      else if (rd_stb_i) snap_q <= pins_i;
   end

   assign mismatch_o = |(pins_i ^ snap_q);
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
   parameter int unsigned N_SRC = 3,
   parameter int unsigned N_PER = 4
) (
   input  logic             prio_mode_i,
   input  logic             ge_i,
   input  logic             pe_i,
   input  logic [N_SRC-1:0] flg_i,
   input  logic [N_SRC-1:0] ena_i,
   input  logic [N_PER-1:0] hp_per_i,
   input  logic [N_PER-1:0] lp_per_i,
   output logic             hp_irq_o,
   output logic             lp_irq_o
);
   logic [N_SRC-1:0] local_pend;

   for (genvar i = 0; i < N_SRC; i++) begin : g_local
      assign local_pend[i] = flg_i[i] & ena_i[i];
   end

   logic any_local, any_hp_per, any_lp_per;
   assign any_local  = |local_pend;
   assign any_hp_per = |hp_per_i;
   assign any_lp_per = |lp_per_i;

   always_comb begin
      if (prio_mode_i) begin
         hp_irq_o = ge_i & (any_local | any_hp_per);
         lp_irq_o = ge_i & pe_i & any_lp_per;
      end else begin
         hp_irq_o = ge_i & (any_local | (pe_i & (any_hp_per | any_lp_per)));
         lp_irq_o = 1'b0;
      end
   end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
   import irq_ctl_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WATCH_W  = 4,
   parameter int unsigned N_PER    = 4,
   parameter logic        PORT_RST = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic               tmr_ovf_i,
   input  logic               ext_edge_i,
   input  logic [WATCH_W-1:0] port_hi_i,
   input  logic               port_rd_i,
   input  logic               prio_mode_i,
   input  logic [N_PER-1:0]   hp_per_req_i,
   input  logic [N_PER-1:0]   lp_per_req_i,
   output logic               hp_irq_o,
   output logic               lp_irq_o
);
   if (DATA_W != REG_W) begin : g_bad_width
      $error("irq_ctl_reg: DATA_W must equal %0d", REG_W);
   end
   if (WATCH_W < 1) begin : g_bad_watch
      $error("irq_ctl_reg: WATCH_W must be at least 1");
   end
   if (N_PER < 1) begin : g_bad_per
      $error("irq_ctl_reg: N_PER must be at least 1");
   end

   logic ge_q, pe_q;
   logic [N_SRC-1:0] ena_q;
   logic [N_SRC-1:0] flg;
   logic [N_SRC-1:0] hw_set;
   logic             port_mismatch;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ge_q  <= 1'b0;
         pe_q  <= 1'b0;
         ena_q <= '0;
      end else if (wr_en_i) begin
         ge_q  <= wr_data_i[BIT_GE];
         pe_q  <= wr_data_i[BIT_PE];
         ena_q <= wr_data_i[ENA_LSB +: N_SRC];
      end
   end

   irq_port_watch #(.WATCH_W(WATCH_W)) u_watch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pins_i     (port_hi_i),
      .rd_stb_i   (port_rd_i),
      .mismatch_o (port_mismatch)
   );

   assign hw_set[SRC_PORT] = port_mismatch;
   assign hw_set[SRC_EXT]  = ext_edge_i;
   assign hw_set[SRC_TMR]  = tmr_ovf_i;

   for (genvar i = 0; i < N_SRC; i++) begin : g_flag
      localparam logic RV = (i == SRC_PORT) ? PORT_RST : 1'b0;
      irq_flag_cell #(.RST_VAL(RV)) u_cell (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .hw_set_i (hw_set[i]),
         .wr_en_i  (wr_en_i),
         .wr_bit_i (wr_data_i[FLG_LSB + i]),
         .q_o      (flg[i])
      );
   end

   assign rd_data_o = {ge_q, pe_q, ena_q, flg};

   irq_req_merge #(.N_SRC(N_SRC), .N_PER(N_PER)) u_merge (
      .prio_mode_i (prio_mode_i),
      .ge_i        (ge_q),
      .pe_i        (pe_q),
      .flg_i       (flg),
      .ena_i       (ena_q),
      .hp_per_i    (hp_per_req_i),
      .lp_per_i    (lp_per_req_i),
      .hp_irq_o    (hp_irq_o),
      .lp_irq_o    (lp_irq_o)
   );
endmodule

module irq_ctl_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_PER   = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              tmr_ovf_i,
   input logic              ext_edge_i,
   input logic              prio_mode_i,
   input logic [N_PER-1:0]  lp_per_req_i,
   input logic              hp_irq_o,
   input logic              lp_irq_o
);
   p_tmr_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_ovf_i |=> rd_data_o[2]);
   p_ext_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_edge_i |=> rd_data_o[1]);
   p_hw_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_data_i[2] && tmr_ovf_i) |=> rd_data_o[2]);
   p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ((rd_data_o[2:0] & $past(rd_data_o[2:0])) == $past(rd_data_o[2:0])));
   p_ena_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(rd_data_o[7:3]));
   p_ge_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_data_o[7] |-> (!hp_irq_o && !lp_irq_o));
   p_no_lp_flat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !prio_mode_i |-> !lp_irq_o);
   p_lp_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lp_irq_o |-> (rd_data_o[6] && prio_mode_i && (|lp_per_req_i)));
endmodule

bind irq_ctl_reg irq_ctl_chk #(.DATA_W(DATA_W), .N_PER(N_PER)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_en_i      (wr_en_i),
   .wr_data_i    (wr_data_i),
   .rd_data_o    (rd_data_o),
   .tmr_ovf_i    (tmr_ovf_i),
   .ext_edge_i   (ext_edge_i),
   .prio_mode_i  (prio_mode_i),
   .lp_per_req_i (lp_per_req_i),
   .hp_irq_o     (hp_irq_o),
   .lp_irq_o     (lp_irq_o)
);

// File: tb/sim_irq_ctl_reg.sv
`timescale 1ns/1ps
module sim_irq_ctl_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       tmr = 1'b0, ext = 1'b0, prd = 1'b0, mode = 1'b0;
   logic [3:0] pins = '0;
   logic [3:0] hpr = '0, lpr = '0;
   logic       hp, lp;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   irq_ctl_reg u0 (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .tmr_ovf_i(tmr), .ext_edge_i(ext),
      .port_hi_i(pins), .port_rd_i(prd), .prio_mode_i(mode),
      .hp_per_req_i(hpr), .lp_per_req_i(lpr), .hp_irq_o(hp), .lp_irq_o(lp)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse_tmr();
      @(negedge clk); tmr = 1'b1;
      @(negedge clk); tmr = 1'b0;
   endtask

   task automatic t_reset();
      #1 chk("R1 reg in reset", rd_data, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reg after reset", rd_data, 8'h00);
      chk("R1 irq after reset", {6'd0, hp, lp}, 8'h00);
   endtask

   task automatic t_rw();
      wr(8'hF8); chk("R2 enables", rd_data, 8'hF8);
      wr(8'h07); chk("R2 flags written", rd_data, 8'h07);
      repeat (2) @(negedge clk);
      chk("R8 hold", rd_data, 8'h07);
      wr(8'h00); chk("R2 clear", rd_data, 8'h00);
   endtask

   task automatic t_events();
      pulse_tmr();
      chk("R3 timer flag", rd_data, 8'h04);
      repeat (3) @(negedge clk);
      chk("R8 timer flag held", rd_data, 8'h04);
      chk("R9 disabled no irq", {6'd0, hp, lp}, 8'h00);
      @(negedge clk); ext = 1'b1;
      @(negedge clk); ext = 1'b0;
      chk("R4 ext flag", rd_data, 8'h06);
      wr(8'h00); chk("R2 flags cleared", rd_data, 8'h00);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h00; tmr = 1'b1;
      @(negedge clk); wr_en = 1'b0; tmr = 1'b0;
      chk("R7 set beats clear", rd_data, 8'h04);
      wr(8'h00);
   endtask

   task automatic t_port();
      @(negedge clk); pins = 4'h1;
      @(negedge clk);
      chk("R5 mismatch sets", rd_data, 8'h01);
      wr(8'h00); chk("R6 clear does not hold", rd_data, 8'h01);
      @(negedge clk); prd = 1'b1;
      @(negedge clk); prd = 1'b0;
      chk("R6 flag after read", rd_data, 8'h01);
      wr(8'h00); @(negedge clk);
      chk("R6 clear holds", rd_data, 8'h00);
      @(negedge clk); pins = 4'h0;
      @(negedge clk);
      chk("R5 return to old value", rd_data, 8'h01);
      @(negedge clk); prd = 1'b1;
      @(negedge clk); prd = 1'b0;
      wr(8'h00);
      chk("R5 quiet after read", rd_data, 8'h00);
   endtask

   task automatic t_mode_off();
      mode = 1'b0;
      pulse_tmr();
      wr(8'hA4); chk("R9 core pending", {6'd0, hp, lp}, 8'h02);
      wr(8'h24); chk("R11 ge clear", {6'd0, hp, lp}, 8'h00);
      wr(8'h80);
      @(negedge clk); lpr = 4'h2; #1;
      chk("R9 periph gated by bit6", {6'd0, hp, lp}, 8'h00);
      wr(8'hC0); chk("R9 periph via bit6", {6'd0, hp, lp}, 8'h02);
      lpr = 4'h0; hpr = 4'h8; #1;
      chk("R9 hp periph via bit6", {6'd0, hp, lp}, 8'h02);
      hpr = 4'h0;
   endtask

   task automatic t_mode_on();
      @(negedge clk); mode = 1'b1; lpr = 4'h1; #1;
      chk("R10 low request", {6'd0, hp, lp}, 8'h01);
      wr(8'h80); chk("R10 low needs bit6", {6'd0, hp, lp}, 8'h00);
      hpr = 4'h4; #1;
      chk("R10 high periph", {6'd0, hp, lp}, 8'h02);
      wr(8'h40); chk("R11 ge clear prio", {6'd0, hp, lp}, 8'h00);
      hpr = 4'h0; lpr = 4'h0;
      pulse_tmr();
      wr(8'hE4); chk("R10 core is high", {6'd0, hp, lp}, 8'h02);
      wr(8'h00);
   endtask

   initial begin
      fork
         begin
            t_reset(); t_rw(); t_events(); t_port(); t_mode_off(); t_mode_on();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule